// File: doc/BRIEF.md
# Prefetching Autoincrement Histogram Readout Port

This block is the readout side of a histogramming memory. A host on a crate-style dataway reads and clears memory words through function-coded commands. It never has to retry a read.

The host first writes an address, which starts a memory read of that word. The result is parked in a data register. Each later read command returns the parked word at once and then launches the next fetch. That fetch is either for the same word or, with the incrementing variant, for the following word. Two clear commands write zero to the addressed word, with or without advancing the address first, and then refetch it. Another pair of commands turns the front-bus (histogram increment) path off and on.

The memory is far faster than the minimum dataway cycle, so the parked word is always ready before the next read. Q is therefore raised for every supported command, whatever the memory is doing. This makes block transfers that ignore Q safe.

Top module: `hist_readout_port`

## Requirements
- R1: While reset is high and in the cycle after it, `data_valid` is 0, `fb_enable` is 1, `mem_req` is 0 and `cmd_rdata` is 0.
- R2: Function 16 loads `cmd_wdata` into the address register. It then issues a memory read of that address (`mem_req`=1, `mem_write`=0). When `mem_ack` arrives, the word is stored and appears on `cmd_rdata`.
- R3: Function 0 returns the parked word in its strobe cycle. It leaves the address unchanged and refetches the same address.
- R4: Function 2 returns the parked word in its strobe cycle. It then increments the address by one and fetches the new address.
- R5: Function 9 clears the word at the current address (`mem_req`=1, `mem_write`=1). It then reads that same address back.
- R6: Function 11 first increments the address. It then clears the word at the new address and reads it back.
- R7: The address register is `ADDR_W` (22) bits wide and wraps from all-ones to zero on increment.
- R8: Function 24 drives `fb_enable` to 0 and function 26 drives it to 1, one cycle after the strobe. Neither command starts a memory access.
- R9: `cmd_q` is 1 in the strobe cycle of the seven supported codes (0, 2, 9, 11, 16, 24, 26) and 0 for any other code. Any other code starts no memory access and leaves the address unchanged.
- R10: `data_valid` falls in the cycle after any command that starts a fetch. It rises in the cycle after the acknowledge of the read that ends the access.
- R11: The host issues read commands (0, 2) only while `data_valid` is 1. It issues a command only while no access is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_strobe | input | 1 | One-cycle command strobe from the dataway |
| cmd_func | input | 5 | Function code |
| cmd_wdata | input | ADDR_W | Address written by function 16 |
| cmd_rdata | output | DATA_W | Parked data register |
| cmd_q | output | 1 | Command accepted response |
| data_valid | output | 1 | Data register holds a completed fetch |
| fb_enable | output | 1 | Front-bus increment path enabled |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_write | output | 1 | 1 = clear (write zero), 0 = read |
| mem_addr | output | ADDR_W | Memory address (address register) |
| mem_ack | input | 1 | Memory access done |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |

## Verification
Two events can meet in one cycle. One is the host taking the parked word from `cmd_rdata`. The other is the launch of the fetch that will overwrite that word. A read strobe returns the old word while the same clock edge moves the address and starts the new read.

The bench provokes this by issuing read commands back to back, as soon as the previous fetch lands, and by giving the memory a random latency. It judges the outcome by comparing each returned word with the memory model's content at the address the bench itself tracks. It then confirms that the next fetch, or the clear followed by the fetch, targets the tracked address, including the wrap at the top of the address space.

// File: rtl/hrp_pkg.sv
package hrp_pkg;

    localparam int FUNC_W = 5;

    localparam logic [FUNC_W-1:0] FN_RD_HOLD  = 5'd0;
    localparam logic [FUNC_W-1:0] FN_RD_NEXT  = 5'd2;
    localparam logic [FUNC_W-1:0] FN_CLR_HOLD = 5'd9;
    localparam logic [FUNC_W-1:0] FN_CLR_NEXT = 5'd11;
    localparam logic [FUNC_W-1:0] FN_ADDR_WR  = 5'd16;
    localparam logic [FUNC_W-1:0] FN_FB_OFF   = 5'd24;
    localparam logic [FUNC_W-1:0] FN_FB_ON    = 5'd26;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_CLEAR,
        SQ_FETCH
    } seq_state_e;

    typedef struct packed {
        logic known;
        logic load;
        logic step;
        logic fetch;
        logic clear;
        logic fb_off;
        logic fb_on;
    } cmd_t;

    function automatic cmd_t decode_func(input logic [FUNC_W-1:0] f);
        cmd_t c;
        c = '0;
        case (f)
            FN_RD_HOLD:  begin c.known = 1'b1; c.fetch = 1'b1; end
            FN_RD_NEXT:  begin c.known = 1'b1; c.fetch = 1'b1; c.step = 1'b1; end
            FN_CLR_HOLD: begin c.known = 1'b1; c.clear = 1'b1; end
            FN_CLR_NEXT: begin c.known = 1'b1; c.clear = 1'b1; c.step = 1'b1; end
            FN_ADDR_WR:  begin c.known = 1'b1; c.fetch = 1'b1; c.load = 1'b1; end
            FN_FB_OFF:   begin c.known = 1'b1; c.fb_off = 1'b1; end
            FN_FB_ON:    begin c.known = 1'b1; c.fb_on = 1'b1; end
            default:     c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/hrp_decode.sv
module hrp_decode
    import hrp_pkg::*;
(
    input  logic              strobe,
    input  logic [FUNC_W-1:0] func,
    output cmd_t              cmd,
    output logic              q
);
    cmd_t raw;

    always_comb begin
        raw = decode_func(func);
        cmd = strobe ? raw : '0;
        q   = strobe & raw.known;
    end
endmodule

// File: rtl/hrp_addr_reg.sv
module hrp_addr_reg #(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (step) begin
            addr <= addr + ONE;
        end
    end
endmodule

// File: rtl/hrp_fetch_seq.sv
module hrp_fetch_seq
    import hrp_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_fetch,
    input  logic              go_clear,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] data_q,
    output logic              valid,
    output logic              mem_req,
    output logic              mem_write
);
    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            data_q <= '0;
            valid  <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (go_clear) begin
                        state <= SQ_CLEAR;
                        valid <= 1'b0;
                    end else if (go_fetch) begin
                        state <= SQ_FETCH;
                        valid <= 1'b0;
                    end
                end
                SQ_CLEAR: begin
                    if (mem_ack) state <= SQ_FETCH;
                end
                SQ_FETCH: begin
                    if (mem_ack) begin
                        data_q <= mem_rdata;
                        valid  <= 1'b1;
                        state  <= SQ_IDLE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = (state != SQ_IDLE);
        mem_write = (state == SQ_CLEAR);
    end
endmodule

// File: rtl/hist_readout_port.sv
module hist_readout_port
    import hrp_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_strobe,
    input  logic [4:0]        cmd_func,
    input  logic [ADDR_W-1:0] cmd_wdata,
    output logic [DATA_W-1:0] cmd_rdata,
    output logic              cmd_q,
    output logic              data_valid,
    output logic              fb_enable,
    output logic              mem_req,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    cmd_t cmd;

    hrp_decode u_dec (
        .strobe (cmd_strobe),
        .func   (cmd_func),
        .cmd    (cmd),
        .q      (cmd_q)
    );

    hrp_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (cmd.load),
        .load_val (cmd_wdata),
        .step     (cmd.step),
        .addr     (mem_addr)
    );

    hrp_fetch_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .go_fetch  (cmd.fetch),
        .go_clear  (cmd.clear),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .data_q    (cmd_rdata),
        .valid     (data_valid),
        .mem_req   (mem_req),
        .mem_write (mem_write)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fb_enable <= 1'b1;
        end else if (cmd.fb_off) begin
            fb_enable <= 1'b0;
        end else if (cmd.fb_on) begin
            fb_enable <= 1'b1;
        end
    end
endmodule

// File: rtl/hrp_checker.sv
module hrp_checker #(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_strobe,
    input logic [4:0]        cmd_func,
    input logic              cmd_q,
    input logic              data_valid,
    input logic              fb_enable,
    input logic              mem_req,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack
);
    logic is_known, is_read, starts_access;

    always_comb begin
        is_known = (cmd_func == 5'd0) || (cmd_func == 5'd2) || (cmd_func == 5'd9) ||
                   (cmd_func == 5'd11) || (cmd_func == 5'd16) || (cmd_func == 5'd24) ||
                   (cmd_func == 5'd26);
        is_read = (cmd_func == 5'd0) || (cmd_func == 5'd2);
        starts_access = is_read || (cmd_func == 5'd9) || (cmd_func == 5'd11) ||
                        (cmd_func == 5'd16);
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!mem_req && !data_valid && fb_enable));

    assert_q_known_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_strobe |-> (cmd_q == is_known));

    assert_unknown_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_strobe && !is_known) |=> (!mem_req && $stable(mem_addr)));

    assert_step_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_strobe && cmd_func == 5'd2) |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    assert_hold_addr_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_strobe && cmd_func == 5'd0) |=> (mem_req && !mem_write && $stable(mem_addr)));

    assert_clear_then_read_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_write && mem_ack) |=> (mem_req && !mem_write && $stable(mem_addr)));

    assert_valid_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_strobe && starts_access) |=> !data_valid);

    assert_valid_rise_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_write && mem_ack) |=> (data_valid && !mem_req));

    assert_fb_off_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_strobe && cmd_func == 5'd24) |=> (!fb_enable && !mem_req));

    assert_fb_on_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_strobe && cmd_func == 5'd26) |=> (fb_enable && !mem_req));

    assert_read_when_valid_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd_strobe && is_read) |-> data_valid);

    assert_cmd_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
        cmd_strobe |-> !mem_req);
endmodule

bind hist_readout_port hrp_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_strobe (cmd_strobe),
    .cmd_func   (cmd_func),
    .cmd_q      (cmd_q),
    .data_valid (data_valid),
    .fb_enable  (fb_enable),
    .mem_req    (mem_req),
    .mem_write  (mem_write),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack)
);

// File: tb/sim_hist_readout_port.sv
`timescale 1ns/1ps
module sim_hist_readout_port;
    localparam int AW = 22;
    localparam int DW = 24;
    localparam logic [AW-1:0] AMAX = {AW{1'b1}};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_strobe = 1'b0;
    logic [4:0]    cmd_func = '0;
    logic [AW-1:0] cmd_wdata = '0;
    logic [DW-1:0] cmd_rdata;
    logic          cmd_q, data_valid, fb_enable, mem_req, mem_write;
    logic [AW-1:0] mem_addr;
    logic          mem_ack;
    logic [DW-1:0] mem_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    int txn = 0;
    logic [AW-1:0] last_rd = '0;
    logic [AW-1:0] last_clr = '0;
    logic [DW-1:0] mem_mod [int];
    logic [AW-1:0] exp_addr = '0;
    logic          exp_fb = 1'b1;

    always #2 clk = ~clk;

    hist_readout_port #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .cmd_strobe(cmd_strobe), .cmd_func(cmd_func),
        .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata), .cmd_q(cmd_q),
        .data_valid(data_valid), .fb_enable(fb_enable), .mem_req(mem_req),
        .mem_write(mem_write), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
        logic [31:0] h;
        h = ({10'd0, a} * 32'h9E3779B1) ^ 32'h005A5A5A;
        return h[DW-1:0] | 24'h000001;
    endfunction

    function automatic logic [DW-1:0] memval(input logic [AW-1:0] a);
        if (mem_mod.exists(int'(a))) return mem_mod[int'(a)];
        return init_val(a);
    endfunction

    // memory responder with random latency
    initial begin
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_req && !rst) begin
                repeat ($urandom_range(2, 0)) @(negedge clk);
                if (mem_write) begin
                    mem_mod[int'(mem_addr)] = '0;
                    last_clr = mem_addr;
                end else begin
                    mem_rdata = memval(mem_addr);
                    last_rd = mem_addr;
                end
                txn++;
                mem_ack = 1'b1;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [4:0] f, input logic [AW-1:0] w,
                         output logic q_s, output logic [DW-1:0] rd_s);
        @(negedge clk);
        cmd_strobe = 1'b1;
        cmd_func = f;
        cmd_wdata = w;
        #0.5;
        q_s = cmd_q;
        rd_s = cmd_rdata;
        @(negedge clk);
        cmd_strobe = 1'b0;
    endtask

    task automatic settle(input bit touches_mem);
        if (touches_mem) begin
            while (mem_req || !data_valid) @(negedge clk);
        end else begin
            repeat (2) @(negedge clk);
        end
    endtask

    // one command, with expected values derived from the bench's own model
    task automatic run_cmd(input logic [4:0] f, input logic [AW-1:0] w);
        logic q_s;
        logic [DW-1:0] rd_s;
        logic [DW-1:0] exp_rd;
        int t0;
        bit known;
        known = (f == 5'd0) || (f == 5'd2) || (f == 5'd9) || (f == 5'd11) ||
                (f == 5'd16) || (f == 5'd24) || (f == 5'd26);
        exp_rd = memval(exp_addr);
        t0 = txn;
        issue(f, w, q_s, rd_s);
        check(known ? "R9 q supported" : "R9 q unsupported", {31'd0, q_s}, {31'd0, known});
        case (f)
            5'd16: begin
                exp_addr = w;
                settle(1'b1);
                check("R2 load fetch addr", {10'd0, last_rd}, {10'd0, exp_addr});
                check("R2 loaded word", {8'd0, cmd_rdata}, {8'd0, memval(exp_addr)});
            end
            5'd0: begin
                check("R3 read word", {8'd0, rd_s}, {8'd0, exp_rd});
                settle(1'b1);
                check("R3 refetch same addr", {10'd0, last_rd}, {10'd0, exp_addr});
            end
            5'd2: begin
                check("R4 read word", {8'd0, rd_s}, {8'd0, exp_rd});
                exp_addr = exp_addr + 1'b1;
                settle(1'b1);
                check("R4/R7 fetch next addr", {10'd0, last_rd}, {10'd0, exp_addr});
            end
            5'd9: begin
                settle(1'b1);
                check("R5 clear addr", {10'd0, last_clr}, {10'd0, exp_addr});
                check("R5 readback zero", {8'd0, cmd_rdata}, 32'd0);
                check("R5 two accesses", txn - t0, 2);
            end
            5'd11: begin
                exp_addr = exp_addr + 1'b1;
                settle(1'b1);
                check("R6 clear next addr", {10'd0, last_clr}, {10'd0, exp_addr});
                check("R6 readback addr", {10'd0, last_rd}, {10'd0, exp_addr});
                check("R6 readback zero", {8'd0, cmd_rdata}, 32'd0);
            end
            5'd24, 5'd26: begin
                exp_fb = (f == 5'd26);
                settle(1'b0);
                check("R8 fb_enable", {31'd0, fb_enable}, {31'd0, exp_fb});
                check("R8 no access", txn - t0, 0);
            end
            default: begin
                settle(1'b0);
                check("R9 unsupported no access", txn - t0, 0);
                check("R9 unsupported keeps data", {8'd0, cmd_rdata}, {8'd0, exp_rd});
            end
        endcase
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [4:0] junk [5];
        junk = '{5'd1, 5'd3, 5'd17, 5'd25, 5'd31};
        void'($urandom(32'd20240607));
        repeat (4) @(negedge clk);
        check("R1 data_valid in reset", {31'd0, data_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 data_valid", {31'd0, data_valid}, 0);
        check("R1 fb_enable", {31'd0, fb_enable}, 1);
        check("R1 mem_req", {31'd0, mem_req}, 0);
        check("R1 rdata", {8'd0, cmd_rdata}, 0);

        // directed corners
        run_cmd(5'd16, AMAX - 1'b1);
        run_cmd(5'd0, '0);
        run_cmd(5'd2, '0);
        run_cmd(5'd2, '0);            // wraps to zero (R7)
        check("R7 wrapped addr", {10'd0, exp_addr}, 0);
        run_cmd(5'd11, '0);
        run_cmd(5'd0, '0);
        run_cmd(5'd16, AW'(5));
        run_cmd(5'd9, '0);
        run_cmd(5'd0, '0);
        run_cmd(5'd24, '0);
        run_cmd(5'd24, '0);
        run_cmd(5'd26, '0);
        run_cmd(5'd7, '0);
        run_cmd(5'd0, '0);
        run_cmd(5'd16, AMAX);
        run_cmd(5'd11, '0);           // clear after wrap (R6, R7)

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            int sel;
            logic [AW-1:0] a;
            sel = $urandom_range(9, 0);
            a = ($urandom_range(1, 0) == 1) ? AW'(AMAX - AW'($urandom_range(15, 0)))
                                             : AW'($urandom_range(63, 0));
            case (sel)
                0:       run_cmd(5'd0, a);
                1, 2, 9: run_cmd(5'd2, a);
                3:       run_cmd(5'd16, a);
                4:       run_cmd(5'd9, a);
                5:       run_cmd(5'd11, a);
                6:       run_cmd(5'd24, a);
                7:       run_cmd(5'd26, a);
                default: run_cmd(junk[$urandom_range(4, 0)], a);
            endcase
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule